// File: doc/BRIEF.md
# Tributary Maintenance Loopback Controller

This block sits on the data path of one multiplexed tributary port, between the terminal-side framer, the line coder and the line-side interface. It steers transmit and receive beats for maintenance work. It can loop transmitted line data back towards the terminal, or loop received data back out to the line. It can replace the outgoing frame with an all-ones alarm signal. It can pace transmission from the recovered receive timing instead of the local timing. It can also corrupt exactly one framing bit on request.

A processor-mode input chooses where four control functions come from. These are the parity enable, the rate mode, the serial/nibble terminal select and the transmit alarm. They come either from dedicated pins or from register bits. The loopback, loop-timing and force-error controls always come from pins and are active low. The whole block runs on one system clock, and both timing sources are modelled as clock-enable strobes. Each data beat is `DW` bits wide and carries a valid flag. The framer also marks the beats that hold a framing bit.

Top module: `trib_maint_loop`

## Requirements
- R1: When `proc_mode` is 1, `par_en_o`, `rate_o` and `serial_o` take the register inputs, and the transmit alarm follows `reg_alarm` (1 = alarm). When `proc_mode` is 0, they take the pin inputs, and the alarm is active while `pin_alarm_n` is 0. `par_en_o`, `rate_o` and `serial_o` are registered with one cycle of latency.
- R2: `coder_bypass_o` equals `nrz_sel` from the previous cycle. A 1 means single-rail data with the line coder bypassed, and a 0 means dual-rail with coding enabled.
- R3: `tx_ce_o` equals, one cycle later, `rx_ce` while `loop_time_n` is 0, and `tx_ce_local` otherwise.
- R4: While `pay_loop_n` is 0 and the effective serial select is 1, the line transmit beat one cycle later is the received line beat (`line_rx_bit`, `line_rx_vld`). Looped beats never count as framing beats.
- R5: While the effective serial select is 0, `pay_loop_n` has no effect, and the terminal transmit beat keeps flowing to the line.
- R6: While `term_loop_n` is 0, `term_rx_bit`/`term_rx_vld` carry the previous cycle's `line_tx_bit`/`line_tx_vld` instead of the received line beat.
- R7: While the effective alarm is active, `line_tx_bit` becomes all ones one cycle later. The valid flag still follows the selected source, so the alarm is applied after the loopback selection.
- R8: Each falling edge of `force_err_n` passes a two-stage synchroniser and arms a request. The request inverts bit `FBIT_POS` of the next valid framing beat (`term_tx_fbit`=1) sent to the line, and is then cleared. Further edges while armed do not add a second error.
- R9: During reset, every output is 0 and any armed error request is discarded.
- R10: With no maintenance function active, `line_tx_bit`/`line_tx_vld` repeat the terminal transmit beat one cycle later, and `term_rx_bit`/`term_rx_vld` repeat the received line beat one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| proc_mode | input | 1 | 1 = register bits control, 0 = pins control |
| pin_par_en | input | 1 | Parity enable pin |
| pin_rate | input | 2 | Rate mode pins |
| pin_serial | input | 1 | Serial (1) / nibble (0) select pin |
| pin_alarm_n | input | 1 | Transmit alarm pin, active low |
| reg_par_en | input | 1 | Parity enable register bit |
| reg_rate | input | 2 | Rate mode register bits |
| reg_serial | input | 1 | Serial select register bit |
| reg_alarm | input | 1 | Transmit alarm register bit, active high |
| term_loop_n | input | 1 | Line-side loopback, active low |
| pay_loop_n | input | 1 | Terminal-side payload loopback, active low |
| loop_time_n | input | 1 | Loop timing, active low |
| force_err_n | input | 1 | Asynchronous force-error request, falling edge |
| nrz_sel | input | 1 | Single-rail coder bypass select |
| tx_ce_local | input | 1 | Local transmit timing strobe |
| rx_ce | input | 1 | Recovered receive timing strobe |
| term_tx_bit | input | DW | Transmit beat from the framer |
| term_tx_fbit | input | 1 | Transmit beat holds a framing bit |
| term_tx_vld | input | 1 | Transmit beat valid |
| line_rx_bit | input | DW | Received beat from the line |
| line_rx_vld | input | 1 | Received beat valid |
| par_en_o | output | 1 | Effective parity enable |
| rate_o | output | 2 | Effective rate mode |
| serial_o | output | 1 | Effective serial select |
| coder_bypass_o | output | 1 | Line coder bypass |
| tx_ce_o | output | 1 | Selected transmit timing strobe |
| line_tx_bit | output | DW | Beat towards the line |
| line_tx_vld | output | 1 | Line beat valid |
| term_rx_bit | output | DW | Beat towards the terminal |
| term_rx_vld | output | 1 | Terminal beat valid |

## Verification
The hardest situation to reach is an armed error request that meets an unusual framing beat. The beat may arrive while the alarm masks it, while a payload loopback hides the framing marks, or while a second falling edge lands just as the request is consumed. The stimulus keeps framing beats periodic and gives `force_err_n` low pulses on a period that is prime with respect to them. It then overlays phases with alarm and payload loopback, so armed requests sit across those conditions. A behavioural model checks on every clock that exactly one bit flips per edge and in which beat it flips.

// File: rtl/trib_maint_pkg.sv
package trib_maint_pkg;
  localparam int RATE_W = 2;

  typedef struct packed {
    logic              par_en;
    logic [RATE_W-1:0] rate;
    logic              serial;
    logic              alarm;
  } maint_ctrl_t;
endpackage

// File: rtl/tm_ctrl_mux.sv
module tm_ctrl_mux
  import trib_maint_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        proc_mode,
  input  maint_ctrl_t pin_ctrl,
  input  maint_ctrl_t reg_ctrl,
  output maint_ctrl_t eff_ctrl,
  output maint_ctrl_t ctrl_q
);
  assign eff_ctrl = proc_mode ? reg_ctrl : pin_ctrl;

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else     ctrl_q <= eff_ctrl;
  end

  // R1
  reg_source_chk: assert property (@(posedge clk) disable iff (rst)
    proc_mode |=> ctrl_q == $past(reg_ctrl));
  // R1
  pin_source_chk: assert property (@(posedge clk) disable iff (rst)
    !proc_mode |=> ctrl_q == $past(pin_ctrl));
endmodule

// File: rtl/tm_force_arm.sv
module tm_force_arm #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic force_n,
  input  logic consume,
  output logic pending
);
  logic [SYNC_N:0] shr;
  logic            fall;

  always_ff @(posedge clk) begin
    if (rst) shr <= '1;
    else     shr <= {shr[SYNC_N-1:0], force_n};
  end

  assign fall = shr[SYNC_N] & ~shr[SYNC_N-1];

  always_ff @(posedge clk) begin
    if (rst) pending <= 1'b0;
    else     pending <= fall | (pending & ~consume);
  end

  // R8
  single_shot_chk: assert property (@(posedge clk) disable iff (rst)
    pending && consume && !fall |=> !pending);
  // R8
  no_spurious_arm_chk: assert property (@(posedge clk) disable iff (rst)
    !pending && !fall |=> !pending);
endmodule

// File: rtl/tm_tx_path.sv
module tm_tx_path #(
  parameter int DW       = 4,
  parameter int FBIT_POS = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] term_bit,
  input  logic          term_fbit,
  input  logic          term_vld,
  input  logic [DW-1:0] loop_bit,
  input  logic          loop_vld,
  input  logic          pay_sel,
  input  logic          alarm,
  input  logic          pending,
  output logic          consume,
  output logic [DW-1:0] line_bit,
  output logic          line_vld
);
  localparam logic [DW-1:0] ERR_MASK = DW'(1) << FBIT_POS;

  logic [DW-1:0] src_bit;
  logic          src_vld;
  logic          src_fbit;
  logic [DW-1:0] err_bit;

  always_comb begin
    src_bit  = pay_sel ? loop_bit : term_bit;
    src_vld  = pay_sel ? loop_vld : term_vld;
    src_fbit = pay_sel ? 1'b0     : term_fbit;
    consume  = pending & src_fbit & src_vld;
    err_bit  = consume ? (src_bit ^ ERR_MASK) : src_bit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_bit <= '0;
      line_vld <= 1'b0;
    end else begin
      line_bit <= alarm ? '1 : err_bit;
      line_vld <= src_vld;
    end
  end

  // R7
  alarm_ones_chk: assert property (@(posedge clk) disable iff (rst)
    alarm |=> line_bit == '1);
  // R4
  payload_loop_chk: assert property (@(posedge clk) disable iff (rst)
    pay_sel && !alarm |=> line_bit == $past(loop_bit) && line_vld == $past(loop_vld));
endmodule

// File: rtl/trib_maint_loop.sv
module trib_maint_loop
  import trib_maint_pkg::*;
#(
  parameter int DW       = 4,
  parameter int FBIT_POS = 0,
  parameter int SYNC_N   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              proc_mode,
  input  logic              pin_par_en,
  input  logic [RATE_W-1:0] pin_rate,
  input  logic              pin_serial,
  input  logic              pin_alarm_n,
  input  logic              reg_par_en,
  input  logic [RATE_W-1:0] reg_rate,
  input  logic              reg_serial,
  input  logic              reg_alarm,
  input  logic              term_loop_n,
  input  logic              pay_loop_n,
  input  logic              loop_time_n,
  input  logic              force_err_n,
  input  logic              nrz_sel,
  input  logic              tx_ce_local,
  input  logic              rx_ce,
  input  logic [DW-1:0]     term_tx_bit,
  input  logic              term_tx_fbit,
  input  logic              term_tx_vld,
  input  logic [DW-1:0]     line_rx_bit,
  input  logic              line_rx_vld,
  output logic              par_en_o,
  output logic [RATE_W-1:0] rate_o,
  output logic              serial_o,
  output logic              coder_bypass_o,
  output logic              tx_ce_o,
  output logic [DW-1:0]     line_tx_bit,
  output logic              line_tx_vld,
  output logic [DW-1:0]     term_rx_bit,
  output logic              term_rx_vld
);
  maint_ctrl_t pin_ctrl, reg_ctrl, eff_ctrl, ctrl_q;
  logic        pending, consume, pay_sel;

  assign pin_ctrl = '{par_en: pin_par_en, rate: pin_rate, serial: pin_serial, alarm: ~pin_alarm_n};
  assign reg_ctrl = '{par_en: reg_par_en, rate: reg_rate, serial: reg_serial, alarm: reg_alarm};

  tm_ctrl_mux u_ctrl (
    .clk(clk), .rst(rst), .proc_mode(proc_mode),
    .pin_ctrl(pin_ctrl), .reg_ctrl(reg_ctrl),
    .eff_ctrl(eff_ctrl), .ctrl_q(ctrl_q)
  );

  assign par_en_o = ctrl_q.par_en;
  assign rate_o   = ctrl_q.rate;
  assign serial_o = ctrl_q.serial;

  tm_force_arm #(.SYNC_N(SYNC_N)) u_arm (
    .clk(clk), .rst(rst), .force_n(force_err_n),
    .consume(consume), .pending(pending)
  );

  assign pay_sel = ~pay_loop_n & eff_ctrl.serial;

  tm_tx_path #(.DW(DW), .FBIT_POS(FBIT_POS)) u_tx (
    .clk(clk), .rst(rst),
    .term_bit(term_tx_bit), .term_fbit(term_tx_fbit), .term_vld(term_tx_vld),
    .loop_bit(line_rx_bit), .loop_vld(line_rx_vld),
    .pay_sel(pay_sel), .alarm(eff_ctrl.alarm), .pending(pending),
    .consume(consume), .line_bit(line_tx_bit), .line_vld(line_tx_vld)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      term_rx_bit    <= '0;
      term_rx_vld    <= 1'b0;
      tx_ce_o        <= 1'b0;
      coder_bypass_o <= 1'b0;
    end else begin
      term_rx_bit    <= term_loop_n ? line_rx_bit : line_tx_bit;
      term_rx_vld    <= term_loop_n ? line_rx_vld : line_tx_vld;
      tx_ce_o        <= loop_time_n ? tx_ce_local : rx_ce;
      coder_bypass_o <= nrz_sel;
    end
  end

  // R6
  term_loop_chk: assert property (@(posedge clk) disable iff (rst)
    !term_loop_n |=> term_rx_bit == $past(line_tx_bit) && term_rx_vld == $past(line_tx_vld));
  // R3
  loop_timing_chk: assert property (@(posedge clk) disable iff (rst)
    !loop_time_n |=> tx_ce_o == $past(rx_ce));
  // R5
  nibble_no_loop_chk: assert property (@(posedge clk) disable iff (rst)
    !eff_ctrl.serial && !eff_ctrl.alarm && !term_tx_fbit |=> line_tx_bit == $past(term_tx_bit));
endmodule

// File: tb/test_trib_maint_loop.sv
module test_trib_maint_loop;
  localparam int DW = 4;
  localparam int FP = 0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic proc_mode = 0, pin_par_en = 0, pin_serial = 0, pin_alarm_n = 1;
  logic reg_par_en = 0, reg_serial = 0, reg_alarm = 0;
  logic [1:0] pin_rate = 0, reg_rate = 0;
  logic term_loop_n = 1, pay_loop_n = 1, loop_time_n = 1, force_err_n = 1, nrz_sel = 0;
  logic tx_ce_local = 0, rx_ce = 0;
  logic [DW-1:0] term_tx_bit = 0, line_rx_bit = 0;
  logic term_tx_fbit = 0, term_tx_vld = 0, line_rx_vld = 0;
  logic par_en_o, serial_o, coder_bypass_o, tx_ce_o, line_tx_vld, term_rx_vld;
  logic [1:0] rate_o;
  logic [DW-1:0] line_tx_bit, term_rx_bit;

  always #10 clk = ~clk;

  trib_maint_loop #(.DW(DW), .FBIT_POS(FP), .SYNC_N(2)) i_trib_maint_loop (
    .clk(clk), .rst(rst), .proc_mode(proc_mode),
    .pin_par_en(pin_par_en), .pin_rate(pin_rate), .pin_serial(pin_serial), .pin_alarm_n(pin_alarm_n),
    .reg_par_en(reg_par_en), .reg_rate(reg_rate), .reg_serial(reg_serial), .reg_alarm(reg_alarm),
    .term_loop_n(term_loop_n), .pay_loop_n(pay_loop_n), .loop_time_n(loop_time_n),
    .force_err_n(force_err_n), .nrz_sel(nrz_sel), .tx_ce_local(tx_ce_local), .rx_ce(rx_ce),
    .term_tx_bit(term_tx_bit), .term_tx_fbit(term_tx_fbit), .term_tx_vld(term_tx_vld),
    .line_rx_bit(line_rx_bit), .line_rx_vld(line_rx_vld),
    .par_en_o(par_en_o), .rate_o(rate_o), .serial_o(serial_o), .coder_bypass_o(coder_bypass_o),
    .tx_ce_o(tx_ce_o), .line_tx_bit(line_tx_bit), .line_tx_vld(line_tx_vld),
    .term_rx_bit(term_rx_bit), .term_rx_vld(term_rx_vld)
  );

  int checks = 0;
  int errors = 0;
  int injections = 0;
  bit model_on = 0;
  bit done = 0;

  // reference model state
  logic e_par, e_ser, e_byp, e_ce, e_txv, e_rxv;
  logic [1:0] e_rate;
  logic [DW-1:0] e_tx, e_rx;
  logic m_s0, m_s1, m_prev, m_pend;
  string tag_ctl, tag_tx, tag_rx;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    logic ser, alm, pl, fall, hit, sv;
    logic [DW-1:0] sb;
    if (rst) begin
      e_par = 0; e_rate = 0; e_ser = 0; e_byp = 0; e_ce = 0;
      e_tx = 0; e_txv = 0; e_rx = 0; e_rxv = 0;
      m_s0 = 1; m_s1 = 1; m_prev = 1; m_pend = 0;
      tag_ctl = "R9"; tag_tx = "R9"; tag_rx = "R9";
    end else begin
      ser = proc_mode ? reg_serial : pin_serial;
      alm = proc_mode ? reg_alarm : !pin_alarm_n;
      fall = m_prev & ~m_s1;
      pl = !pay_loop_n && ser;
      sb = pl ? line_rx_bit : term_tx_bit;
      sv = pl ? line_rx_vld : term_tx_vld;
      hit = !pl && term_tx_fbit && sv && m_pend;
      if (hit) begin
        sb[FP] = ~sb[FP];
        injections++;
      end
      // receive side uses the line beat from before this edge
      if (!term_loop_n) begin
        e_rx = e_tx; e_rxv = e_txv; tag_rx = "R6";
      end else begin
        e_rx = line_rx_bit; e_rxv = line_rx_vld; tag_rx = "R10";
      end
      e_tx = alm ? '1 : sb;
      e_txv = sv;
      if (alm) tag_tx = "R7";
      else if (hit) tag_tx = "R8";
      else if (pl) tag_tx = "R4";
      else if (!pay_loop_n) tag_tx = "R5";
      else tag_tx = "R10";
      e_par = proc_mode ? reg_par_en : pin_par_en;
      e_rate = proc_mode ? reg_rate : pin_rate;
      e_ser = ser;
      tag_ctl = "R1";
      e_byp = nrz_sel;
      e_ce = loop_time_n ? tx_ce_local : rx_ce;
      m_pend = fall | (m_pend & ~hit);
      m_prev = m_s1; m_s1 = m_s0; m_s0 = force_err_n;
    end
    model_on = 1;
  end

  always @(negedge clk) begin
    if (model_on && !done) begin
      check(tag_ctl, {7'd0, par_en_o}, {7'd0, e_par}, "par_en_o");
      check(tag_ctl, {6'd0, rate_o}, {6'd0, e_rate}, "rate_o");
      check(tag_ctl, {7'd0, serial_o}, {7'd0, e_ser}, "serial_o");
      check(rst ? "R9" : "R2", {7'd0, coder_bypass_o}, {7'd0, e_byp}, "coder_bypass_o");
      check(rst ? "R9" : "R3", {7'd0, tx_ce_o}, {7'd0, e_ce}, "tx_ce_o");
      check(tag_tx, {4'd0, line_tx_bit}, {4'd0, e_tx}, "line_tx_bit");
      check(tag_tx, {7'd0, line_tx_vld}, {7'd0, e_txv}, "line_tx_vld");
      check(tag_rx, {4'd0, term_rx_bit}, {4'd0, e_rx}, "term_rx_bit");
      check(tag_rx, {7'd0, term_rx_vld}, {7'd0, e_rxv}, "term_rx_vld");
    end
  end

  int cyc = 0;

  task automatic run(input int n, input bit pm, input bit ser, input bit alm,
                     input bit pl_n, input bit tl_n, input bit lt_n, input bit frc);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cyc++;
      proc_mode = pm;
      pin_serial = pm ? logic'($urandom_range(0, 1)) : ser;
      reg_serial = pm ? ser : logic'($urandom_range(0, 1));
      pin_alarm_n = pm ? logic'($urandom_range(0, 1)) : !alm;
      reg_alarm = pm ? alm : logic'($urandom_range(0, 1));
      pin_par_en = logic'($urandom_range(0, 1));
      reg_par_en = logic'($urandom_range(0, 1));
      pin_rate = 2'($urandom_range(0, 3));
      reg_rate = 2'($urandom_range(0, 3));
      pay_loop_n = pl_n;
      term_loop_n = tl_n;
      loop_time_n = lt_n;
      nrz_sel = ((cyc / 13) % 2) == 1;
      tx_ce_local = logic'($urandom_range(0, 1));
      rx_ce = logic'($urandom_range(0, 1));
      term_tx_bit = DW'($urandom_range(0, 15));
      line_rx_bit = DW'($urandom_range(0, 15));
      term_tx_vld = ($urandom_range(0, 3) != 0);
      line_rx_vld = ($urandom_range(0, 3) != 0);
      term_tx_fbit = (cyc % 8) == 0;
      if (frc) force_err_n = !((cyc % 29) < 3 || (cyc % 53) == 7);
      else force_err_n = 1'b1;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    run(300, 0, 0, 0, 1, 1, 1, 0);   // R10 passthrough, pin mode
    run(300, 1, 0, 0, 1, 1, 1, 0);   // R1 register mode
    run(300, 0, 1, 0, 0, 1, 1, 0);   // R4 payload loop, serial
    run(300, 0, 0, 0, 0, 1, 1, 0);   // R5 payload loop ignored in nibble mode
    run(300, 1, 1, 0, 0, 1, 1, 0);   // R4 via register serial select
    run(300, 0, 0, 0, 1, 0, 1, 0);   // R6 terminal loopback
    run(300, 1, 0, 1, 1, 0, 0, 0);   // R7 alarm after loopback, R3 loop timing
    run(600, 0, 0, 0, 1, 1, 1, 1);   // R8 error injection
    run(400, 0, 0, 1, 1, 1, 0, 1);   // R8 armed under alarm
    run(400, 0, 1, 0, 0, 0, 1, 1);   // R8 armed across payload loop
    run(300, 1, 0, 0, 1, 1, 1, 1);   // R8 in register mode
    @(negedge clk);
    rst = 1;
    force_err_n = 0;
    repeat (3) @(negedge clk);       // R9 reset state mid-run
    rst = 0;
    force_err_n = 1;
    run(200, 0, 0, 0, 1, 1, 1, 0);   // R9 no stale error after reset
    @(negedge clk);
    if (injections == 0) begin
      errors++;
      $display("FAIL R8 no framing error injected: actual=0 expected>0");
    end
    checks++;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule